// File: doc/BRIEF.md
# Window Readout Sequencer

This block produces the scan order for reading out a 640 by 480 pixel array. It walks a row address and a column address through a window of interest that software sets up. Inside that window it can skip rows and columns in fixed steps, which gives a digital zoom. Alongside the addresses it drives frame-valid and line-valid strobes for a video encoder downstream. Each clock with line-valid high carries one pixel address, so line-valid also acts as the pixel qualifier. The block emits addresses and strobes only. Pixel data is handled elsewhere.

Frame rate is set by two values: idle clocks appended to every line, and idle line times appended to every frame. The master clock never changes. In interlaced mode, alternate frames carry alternate rows of the subsampled window, and a field flag reports which set is being read.

Configuration is written through a plain address/data write port into pending registers. The sequencer copies the pending registers into its working copy only at a frame boundary. Values that fall outside the array, or windows whose start lies past their stop, are repaired on that copy.

Top module: `win_readout_seq`

## Requirements
- R1: While `rstN` is low, `frameValid`, `lineValid` and `fieldId` are 0. The frame after reset scans the full array in progressive order with steps of 1. Its first pixel appears two clocks after the first rising edge with `rstN` high. Blanking defaults are `HB_DEF` clocks and `VB_DEF` line times.
- R2: Pixels come out one per clock in row-major order with `lineValid` high, on `rowAddr`/`colAddr`. The window bounds are held at write addresses 0 (first column), 1 (last column), 2 (first row) and 3 (last row), in `wrData`.
- R3: A bound above the array's last index is replaced by that last index. After that, a first bound greater than its last bound is replaced by the last bound.
- R4: Write address 4 holds the column step in `wrData[3:0]` and the row step in `wrData[11:8]`. A step of 0 acts as 1. The columns of a line are first, first+step and so on, while not past the last column. Rows follow the same rule.
- R5: A 1x1 window with zero horizontal and zero vertical blanking gives a frame period of three clocks: one pixel, then two clocks with both strobes low.
- R6: After the last pixel of each line come the horizontal blanking clocks (write address 5, 0 allowed), with `lineValid` low.
- R7: After the last line, the vertical blanking (write address 6, counted in line times) runs with `frameValid` low. One line time equals the pixels per line plus the horizontal blanking. Then come two boundary clocks, after which the next frame starts.
- R8: `frameValid` rises with the first pixel of a frame and falls the clock after its last pixel. It stays high across the blanking between lines. `lineValid` is never high without `frameValid`.
- R9: Write address 7 bit 0 selects interlaced mode. The subsampled rows are numbered k = 0, 1, 2 and so on. Field 0 reads the even k and field 1 reads the odd k, and `fieldId` shows the field. Fields alternate frame by frame, and the first interlaced frame after a progressive one is field 0. A field with no rows becomes a frame made only of vertical blanking.
- R10: Writes go to pending registers and take effect only at the next frame boundary. A frame in progress keeps its original window, steps, blanking and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| frameValid | output | 1 | High from first to last pixel of a frame |
| lineValid | output | 1 | High on each clock carrying a pixel address |
| fieldId | output | 1 | Current interlace field (0 in progressive mode) |
| rowAddr | output | $clog2(ROWS) | Row address of the current pixel |
| colAddr | output | $clog2(COLS) | Column address of the current pixel |

## Verification
The hardest situations to reach are the short frames: an interlaced field that contains no rows, and a 1x1 window with no blanking. Both only appear after a frame boundary. They last a few clocks each, which is shorter than the eight writes needed to set up a new configuration. The stimulus therefore writes each next configuration while a long frame is running. It chains frames back to back with a cycle-exact model of the expected scan, and it orders the scenarios so that the shortest frames come last. Because every write lands in the middle of a frame, each frame comparison also shows that the running frame is not torn.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] REG_COL_FIRST = 3'd0;
  localparam logic [ADDR_W-1:0] REG_COL_LAST  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_ROW_FIRST = 3'd2;
  localparam logic [ADDR_W-1:0] REG_ROW_LAST  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_STEPS     = 3'd4;
  localparam logic [ADDR_W-1:0] REG_HBLANK    = 3'd5;
  localparam logic [ADDR_W-1:0] REG_VBLANK    = 3'd6;
  localparam logic [ADDR_W-1:0] REG_MODE      = 3'd7;

  localparam int ROW_STEP_LSB = 8;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_START,
    ST_WALK,
    ST_HBL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic colAdv;
    logic rowAdv;
    logic hClr;
    logic hAdv;
    logic vClr;
    logic vAdv;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic colEnd;
    logic rowEnd;
    logic fieldEmpty;
    logic hZero;
    logic hEnd;
    logic vZero;
    logic vEnd;
  } seqSts_t;
endpackage

// File: rtl/wrs_cfg_regs.sv
module wrs_cfg_regs
  import wrs_pkg::*;
#(
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int STEP_W = 4,
  parameter int HB_W   = 12,
  parameter int VB_W   = 10,
  parameter int HB_DEF = 160,
  parameter int VB_DEF = 45
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [$clog2(COLS)-1:0]    nColFirst,
  output logic [$clog2(COLS)-1:0]    nColLast,
  output logic [$clog2(ROWS)-1:0]    nRowFirst,
  output logic [$clog2(ROWS)-1:0]    nRowLast,
  output logic [STEP_W-1:0]          nColStep,
  output logic [STEP_W-1:0]          nRowStep,
  output logic [HB_W-1:0]            nHBlank,
  output logic [VB_W-1:0]            nVBlank,
  output logic                       nInterlace
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam logic [DATA_W-1:0] COL_MAX = DATA_W'(COLS - 1);
  localparam logic [DATA_W-1:0] ROW_MAX = DATA_W'(ROWS - 1);

  logic [DATA_W-1:0] colFirstRaw, colLastRaw, rowFirstRaw, rowLastRaw;
  logic [STEP_W-1:0] colStepRaw, rowStepRaw;
  logic [HB_W-1:0]   hbRaw;
  logic [VB_W-1:0]   vbRaw;
  logic              ilRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colFirstRaw <= '0;
      colLastRaw  <= COL_MAX;
      rowFirstRaw <= '0;
      rowLastRaw  <= ROW_MAX;
      colStepRaw  <= STEP_W'(1);
      rowStepRaw  <= STEP_W'(1);
      hbRaw       <= HB_W'(HB_DEF);
      vbRaw       <= VB_W'(VB_DEF);
      ilRaw       <= 1'b0;
    end else if (wrEn) begin
      unique case (wrAddr)
        REG_COL_FIRST: colFirstRaw <= wrData;
        REG_COL_LAST:  colLastRaw  <= wrData;
        REG_ROW_FIRST: rowFirstRaw <= wrData;
        REG_ROW_LAST:  rowLastRaw  <= wrData;
        REG_STEPS: begin
          colStepRaw <= wrData[STEP_W-1:0];
          rowStepRaw <= wrData[ROW_STEP_LSB +: STEP_W];
        end
        REG_HBLANK:    hbRaw <= wrData[HB_W-1:0];
        REG_VBLANK:    vbRaw <= wrData[VB_W-1:0];
        REG_MODE:      ilRaw <= wrData[0];
        default: ;
      endcase
    end
  end

  function automatic logic [DATA_W-1:0] limitTo(input logic [DATA_W-1:0] v,
                                                 input logic [DATA_W-1:0] maxV);
    return (v > maxV) ? maxV : v;
  endfunction

  logic [DATA_W-1:0] colLastC, colFirstL, colFirstC;
  logic [DATA_W-1:0] rowLastC, rowFirstL, rowFirstC;

  always_comb begin
    colLastC  = limitTo(colLastRaw, COL_MAX);
    colFirstL = limitTo(colFirstRaw, COL_MAX);
    colFirstC = (colFirstL > colLastC) ? colLastC : colFirstL;
    rowLastC  = limitTo(rowLastRaw, ROW_MAX);
    rowFirstL = limitTo(rowFirstRaw, ROW_MAX);
    rowFirstC = (rowFirstL > rowLastC) ? rowLastC : rowFirstL;
  end

  assign nColFirst  = colFirstC[CW-1:0];
  assign nColLast   = colLastC[CW-1:0];
  assign nRowFirst  = rowFirstC[RW-1:0];
  assign nRowLast   = rowLastC[RW-1:0];
  assign nColStep   = (colStepRaw == '0) ? STEP_W'(1) : colStepRaw;
  assign nRowStep   = (rowStepRaw == '0) ? STEP_W'(1) : rowStepRaw;
  assign nHBlank    = hbRaw;
  assign nVBlank    = vbRaw;
  assign nInterlace = ilRaw;
endmodule

// File: rtl/wrs_datapath.sv
module wrs_datapath
  import wrs_pkg::*;
#(
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int STEP_W = 4,
  parameter int HB_W   = 12,
  parameter int VB_W   = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCmd_t                 cmd,
  input  logic [$clog2(COLS)-1:0] nColFirst,
  input  logic [$clog2(COLS)-1:0] nColLast,
  input  logic [$clog2(ROWS)-1:0] nRowFirst,
  input  logic [$clog2(ROWS)-1:0] nRowLast,
  input  logic [STEP_W-1:0]       nColStep,
  input  logic [STEP_W-1:0]       nRowStep,
  input  logic [HB_W-1:0]         nHBlank,
  input  logic [VB_W-1:0]         nVBlank,
  input  logic                    nInterlace,
  output logic [$clog2(ROWS)-1:0] rowAddr,
  output logic [$clog2(COLS)-1:0] colAddr,
  output logic                    fieldId,
  output seqSts_t                 sts
);
  localparam int CW  = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int RXW = RW + 1;            // row may start past the window in field 1
  localparam int CSW = CW + STEP_W;
  localparam int RSW = RXW + STEP_W + 1;

  logic [CW-1:0]     colF, colL, col;
  logic [RW-1:0]     rowL;
  logic [RXW-1:0]    row;
  logic [STEP_W-1:0] colStep, rowStep;
  logic [HB_W-1:0]   hb, hCnt;
  logic [VB_W-1:0]   vb, vCnt;
  logic              il, field;

  logic              nField;
  logic [RXW-1:0]    rowStart;
  logic [CSW-1:0]    colSum;
  logic [STEP_W:0]   rowInc;
  logic [RSW-1:0]    rowSum;

  always_comb begin
    nField   = nInterlace & il & ~field;
    rowStart = RXW'(nRowFirst) + (nField ? RXW'(nRowStep) : RXW'(0));
    colSum   = CSW'(col) + CSW'(colStep);
    rowInc   = il ? {rowStep, 1'b0} : {1'b0, rowStep};
    rowSum   = RSW'(row) + RSW'(rowInc);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colF    <= '0;
      colL    <= CW'(COLS - 1);
      rowL    <= RW'(ROWS - 1);
      colStep <= STEP_W'(1);
      rowStep <= STEP_W'(1);
      hb      <= '0;
      vb      <= '0;
      il      <= 1'b0;
      col     <= '0;
      row     <= '0;
      field   <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else begin
      if (cmd.load) begin
        colF    <= nColFirst;
        colL    <= nColLast;
        rowL    <= nRowLast;
        colStep <= nColStep;
        rowStep <= nRowStep;
        hb      <= nHBlank;
        vb      <= nVBlank;
        il      <= nInterlace;
        field   <= nField;
        col     <= nColFirst;
        row     <= rowStart;
      end
      if (cmd.colAdv) col <= sts.colEnd ? colF : colSum[CW-1:0];
      if (cmd.rowAdv) row <= rowSum[RXW-1:0];
      if (cmd.hClr)      hCnt <= '0;
      else if (cmd.hAdv) hCnt <= hCnt + HB_W'(1);
      if (cmd.vClr)      vCnt <= '0;
      else if (cmd.vAdv) vCnt <= vCnt + VB_W'(1);
    end
  end

  always_comb begin
    sts.colEnd     = colSum > CSW'(colL);
    sts.rowEnd     = rowSum > RSW'(rowL);
    sts.fieldEmpty = row > RXW'(rowL);
    sts.hZero      = (hb == '0);
    sts.hEnd       = (hCnt == hb - HB_W'(1));
    sts.vZero      = (vb == '0);
    sts.vEnd       = (vCnt == vb - VB_W'(1));
  end

  assign rowAddr = row[RW-1:0];
  assign colAddr = col;
  assign fieldId = field;
endmodule

// File: rtl/wrs_control.sv
module wrs_control
  import wrs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  seqSts_t sts,
  output seqCmd_t cmd,
  output logic    frameValid,
  output logic    lineValid
);
  seqState_t st, stNext;
  logic      inVb, inVbNext;
  logic      lineEnd;

  always_comb begin
    cmd      = '0;
    stNext   = st;
    inVbNext = inVb;
    lineEnd  = 1'b0;
    unique case (st)
      ST_LOAD: begin
        cmd.load = 1'b1;
        stNext   = ST_START;
      end
      ST_START: begin
        if (!sts.fieldEmpty) begin
          stNext   = ST_WALK;
          inVbNext = 1'b0;
        end else if (!sts.vZero) begin
          stNext   = ST_WALK;
          inVbNext = 1'b1;
          cmd.vClr = 1'b1;
        end else begin
          stNext = ST_LOAD;
        end
      end
      ST_WALK: begin
        cmd.colAdv = 1'b1;
        if (sts.colEnd) begin
          if (!sts.hZero) begin
            cmd.hClr = 1'b1;
            stNext   = ST_HBL;
          end else begin
            lineEnd = 1'b1;
          end
        end
      end
      ST_HBL: begin
        cmd.hAdv = 1'b1;
        if (sts.hEnd) lineEnd = 1'b1;
      end
      default: stNext = ST_LOAD;
    endcase

    if (lineEnd) begin
      if (!inVb) begin
        if (sts.rowEnd) begin
          if (!sts.vZero) begin
            inVbNext = 1'b1;
            cmd.vClr = 1'b1;
            stNext   = ST_WALK;
          end else begin
            stNext = ST_LOAD;
          end
        end else begin
          cmd.rowAdv = 1'b1;
          stNext     = ST_WALK;
        end
      end else if (sts.vEnd) begin
        stNext = ST_LOAD;
      end else begin
        cmd.vAdv = 1'b1;
        stNext   = ST_WALK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_LOAD;
      inVb <= 1'b0;
    end else begin
      st   <= stNext;
      inVb <= inVbNext;
    end
  end

  assign lineValid  = (st == ST_WALK) && !inVb;
  assign frameValid = !inVb && ((st == ST_WALK) || ((st == ST_HBL) && !sts.rowEnd));
endmodule

// File: rtl/win_readout_seq.sv
module win_readout_seq
  import wrs_pkg::*;
#(
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int STEP_W = 4,
  parameter int HB_W   = 12,
  parameter int VB_W   = 10,
  parameter int HB_DEF = 160,
  parameter int VB_DEF = 45
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [2:0]              wrAddr,
  input  logic [15:0]             wrData,
  output logic                    frameValid,
  output logic                    lineValid,
  output logic                    fieldId,
  output logic [$clog2(ROWS)-1:0] rowAddr,
  output logic [$clog2(COLS)-1:0] colAddr
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic [CW-1:0]     nColFirst, nColLast;
  logic [RW-1:0]     nRowFirst, nRowLast;
  logic [STEP_W-1:0] nColStep, nRowStep;
  logic [HB_W-1:0]   nHBlank;
  logic [VB_W-1:0]   nVBlank;
  logic              nInterlace;
  seqCmd_t           cmd;
  seqSts_t           sts;

  wrs_cfg_regs #(
    .COLS(COLS), .ROWS(ROWS), .STEP_W(STEP_W), .HB_W(HB_W), .VB_W(VB_W),
    .HB_DEF(HB_DEF), .VB_DEF(VB_DEF)
  ) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .nColFirst(nColFirst), .nColLast(nColLast),
    .nRowFirst(nRowFirst), .nRowLast(nRowLast),
    .nColStep(nColStep), .nRowStep(nRowStep),
    .nHBlank(nHBlank), .nVBlank(nVBlank), .nInterlace(nInterlace)
  );

  wrs_control ctrl_i (
    .clk(clk), .rstN(rstN), .sts(sts), .cmd(cmd),
    .frameValid(frameValid), .lineValid(lineValid)
  );

  wrs_datapath #(
    .COLS(COLS), .ROWS(ROWS), .STEP_W(STEP_W), .HB_W(HB_W), .VB_W(VB_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .nColFirst(nColFirst), .nColLast(nColLast),
    .nRowFirst(nRowFirst), .nRowLast(nRowLast),
    .nColStep(nColStep), .nRowStep(nRowStep),
    .nHBlank(nHBlank), .nVBlank(nVBlank), .nInterlace(nInterlace),
    .rowAddr(rowAddr), .colAddr(colAddr), .fieldId(fieldId), .sts(sts)
  );
endmodule

// File: rtl/wrs_seq_chk.sv
module wrs_seq_chk #(
  parameter int COLS = 640,
  parameter int ROWS = 480
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    frameValid,
  input logic                    lineValid,
  input logic                    fieldId,
  input logic [$clog2(ROWS)-1:0] rowAddr,
  input logic [$clog2(COLS)-1:0] colAddr
);
  // R8: a pixel is only ever presented inside a frame
  a_r8_line_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> frameValid);

  // R3: emitted addresses always lie within the array
  a_r3_addr_in_array: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (int'(colAddr) <= COLS - 1 && int'(rowAddr) <= ROWS - 1));

  // R2: within one line the column address only moves forward
  a_r2_col_forward: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && $past(lineValid) && rowAddr == $past(rowAddr))
      |-> colAddr > $past(colAddr));

  // R9: the field flag does not change while a frame is running
  a_r9_field_steady: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && $past(frameValid)) |-> $stable(fieldId));

  // R7: a frame boundary always leaves frameValid low for more than one clock
  a_r7_frame_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameValid) |=> !frameValid);
endmodule

bind win_readout_seq wrs_seq_chk #(.COLS(COLS), .ROWS(ROWS)) chk_i (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
  .fieldId(fieldId), .rowAddr(rowAddr), .colAddr(colAddr)
);

// File: tb/win_readout_seq_tb_top.sv
module win_readout_seq_tb_top;
  localparam int COLS = 32;
  localparam int ROWS = 16;
  localparam int HBD  = 8;
  localparam int VBD  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        frameValid, lineValid, fieldId;
  logic [$clog2(ROWS)-1:0] rowAddr;
  logic [$clog2(COLS)-1:0] colAddr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int cf; int cl; int rf; int rl; int cs; int rs; int hb; int vb; int il;
  } cfg_t;

  win_readout_seq #(
    .COLS(COLS), .ROWS(ROWS), .HB_DEF(HBD), .VB_DEF(VBD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameValid(frameValid), .lineValid(lineValid), .fieldId(fieldId),
    .rowAddr(rowAddr), .colAddr(colAddr)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // compare one cycle at the current negedge, then step to the next negedge
  task automatic expCycle(string tag, int fv, int lv, int r, int c, int fld);
    chk({tag, " frameValid"}, int'(frameValid), fv);
    chk({tag, " lineValid"}, int'(lineValid), lv);
    if (lv != 0) begin
      chk({tag, " rowAddr"}, int'(rowAddr), r);
      chk({tag, " colAddr"}, int'(colAddr), c);
      chk({tag, " fieldId"}, int'(fieldId), fld);
    end
    @(negedge clk);
  endtask

  function automatic int minI(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // expected working configuration from written values
  function automatic cfg_t repair(cfg_t w);
    cfg_t c = w;
    c.cl = minI(w.cl, COLS - 1);
    c.cf = minI(w.cf, COLS - 1);
    if (c.cf > c.cl) c.cf = c.cl;
    c.rl = minI(w.rl, ROWS - 1);
    c.rf = minI(w.rf, ROWS - 1);
    if (c.rf > c.rl) c.rf = c.rl;
    if (c.cs == 0) c.cs = 1;
    if (c.rs == 0) c.rs = 1;
    return c;
  endfunction

  // one full frame period starting at the negedge of its first cycle
  task automatic scanFrame(cfg_t w, int fld, string tag);
    cfg_t c = repair(w);
    int nPix = 0;
    int inc = (c.il != 0) ? 2 * c.rs : c.rs;
    int r0 = c.rf + ((c.il != 0 && fld != 0) ? c.rs : 0);
    for (int x = c.cf; x <= c.cl; x += c.cs) nPix++;
    for (int r = r0; r <= c.rl; r += inc) begin
      bit last = (r + inc > c.rl);
      for (int x = c.cf; x <= c.cl; x += c.cs) expCycle(tag, 1, 1, r, x, fld);
      for (int h = 0; h < c.hb; h++) expCycle(tag, last ? 0 : 1, 0, 0, 0, fld);
    end
    for (int v = 0; v < c.vb * (nPix + c.hb); v++) expCycle(tag, 0, 0, 0, 0, fld);
    expCycle(tag, 0, 0, 0, 0, fld);
    expCycle(tag, 0, 0, 0, 0, fld);
  endtask

  task automatic writeReg(int a, int d);
    wrEn = 1'b1;
    wrAddr = 3'(a);
    wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeCfg(cfg_t w);
    writeReg(0, w.cf);
    writeReg(1, w.cl);
    writeReg(2, w.rf);
    writeReg(3, w.rl);
    writeReg(4, (w.cs & 15) | ((w.rs & 15) << 8));
    writeReg(5, w.hb);
    writeReg(6, w.vb);
    writeReg(7, w.il);
  endtask

  cfg_t cfgDef, cfgWin, cfgSub, cfgIl, cfgIl1, cfgClamp, cfgTiny;

  task automatic testReset();
    repeat (4) @(negedge clk);
    chk("R1 reset frameValid", int'(frameValid), 0);
    chk("R1 reset lineValid", int'(lineValid), 0);
    chk("R1 reset fieldId", int'(fieldId), 0);
    rstN = 1'b1;
    @(negedge clk);
    expCycle("R1 boundary after reset", 0, 0, 0, 0, 0);
  endtask

  task automatic testDefaultFrame();
    fork
      scanFrame(cfgDef, 0, "R1 default full frame");
      writeCfg(cfgWin);
    join
  endtask

  task automatic testWindowBlank();
    fork
      scanFrame(cfgWin, 0, "R2 R6 R7 R8 R10 window");
      writeCfg(cfgSub);
    join
  endtask

  task automatic testSubsample();
    fork
      scanFrame(cfgSub, 0, "R4 step");
      writeCfg(cfgIl);
    join
  endtask

  task automatic testInterlace();
    scanFrame(cfgIl, 0, "R9 field0");
    fork
      scanFrame(cfgIl, 1, "R9 field1");
      writeCfg(cfgIl1);
    join
    scanFrame(cfgIl1, 0, "R9 single row field0");
    fork
      scanFrame(cfgIl1, 1, "R9 empty field1");
      writeCfg(cfgClamp);
    join
  endtask

  task automatic testClamp();
    fork
      scanFrame(cfgClamp, 0, "R3 clamp");
      writeCfg(cfgTiny);
    join
  endtask

  task automatic testTinyWindow();
    for (int i = 0; i < 3; i++) scanFrame(cfgTiny, 0, "R5 one pixel");
  endtask

  initial begin
    cfgDef   = '{cf:0, cl:COLS-1, rf:0, rl:ROWS-1, cs:1, rs:1, hb:HBD, vb:VBD, il:0};
    cfgWin   = '{cf:5, cl:12, rf:3, rl:7, cs:1, rs:1, hb:3, vb:2, il:0};
    cfgSub   = '{cf:1, cl:10, rf:0, rl:6, cs:3, rs:2, hb:4, vb:1, il:0};
    cfgIl    = '{cf:4, cl:9, rf:2, rl:9, cs:1, rs:1, hb:2, vb:1, il:1};
    cfgIl1   = '{cf:5, cl:12, rf:5, rl:5, cs:1, rs:1, hb:3, vb:2, il:1};
    cfgClamp = '{cf:50, cl:100, rf:10, rl:3, cs:0, rs:0, hb:10, vb:1, il:0};
    cfgTiny  = '{cf:7, cl:7, rf:4, rl:4, cs:1, rs:1, hb:0, vb:0, il:0};
    testReset();
    testDefaultFrame();
    testWindowBlank();
    testSubsample();
    testInterlace();
    testClamp();
    testTinyWindow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule